// File: doc/BRIEF.md
# Element-Width Repacking Unit

This unit takes one 64-bit register value, treats it as a short vector of VL elements at a source element width, ORs an immediate into every element, and packs the results into a 64-bit word at a destination element width. The two widths are chosen independently, so the unit can widen (for example bytes into halfwords) or narrow elements as it repacks them. An endian input decides which end of the register holds element 0, for both the source and the destination.

A request is a one-cycle `start` pulse while `busy` is low. The unit captures its inputs and answers with a one-cycle `valid` pulse carrying `result` and `err`. When both widths are equal, or VL is zero, a word-parallel path finishes in two cycles. When the widths differ, a single element mover handles one element per cycle, so the latency grows with VL. A request whose elements do not fit in 64 bits answers at once with the error flag.

The controller has four states. S_IDLE waits for a request. On acceptance it moves to S_DONE for an oversize request, to S_FAST when widths match or VL is zero, and otherwise to S_STEP. S_FAST computes the whole word and moves to S_DONE. S_STEP places one element per cycle and moves to S_DONE after the last element. S_DONE presents the answer for one cycle and returns to S_IDLE.

Top module: `elw_repack`

## Requirements
- R1: Width codes are 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64 for both `sw_sel` and `dw_sel`. With `be_mode` = 0, element i is read from source bits starting at i×sw and written at destination bits starting at i×dw; VL=4, sw=8, dw=16, source 0x0123456789abcdef, immediate 0 gives 0x0089_00ab_00cd_00ef.
- R2: With `be_mode` = 1, element i is read starting at bit 64−(i+1)×sw and written starting at bit 64−(i+1)×dw; the R1 case gives 0x0001_0023_0045_0067.
- R3: Each result element is the source element ORed with the immediate, the immediate first masked to its low dw bits; a source element narrower than dw is zero-extended.
- R4: When dw is narrower than sw, each result element keeps only the low dw bits of the source element ORed with the masked immediate.
- R5: All result bits outside the VL×dw written region are zero.
- R6: If VL×dw > 64 or VL×sw > 64, the answer has `err` = 1 and `result` = 0; otherwise `err` = 0.
- R7: Counting clock edges from the accepting edge, `valid` rises after 2 edges when sw = dw or VL = 0, after VL+1 edges when widths differ, and after 1 edge for an R6 error.
- R8: `valid` is high for exactly one cycle; `busy` is high from the edge after acceptance through the `valid` cycle; `start` while `busy` is ignored; after reset `valid`, `busy`, `err` and `result` are 0.
- R9: VL = 0 yields `result` = 0 with `err` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken when busy is low |
| src_word | input | 64 | Source register value |
| sw_sel | input | 2 | Source element width code |
| dw_sel | input | 2 | Destination element width code |
| vl | input | 7 | Element count, 0 to 64 |
| imm | input | IMM_W (16) | Immediate ORed into each element |
| be_mode | input | 1 | 1 selects big-endian element indexing |
| busy | output | 1 | Request in progress |
| valid | output | 1 | One-cycle answer strobe |
| err | output | 1 | Oversize request, qualified by valid |
| result | output | 64 | Packed result, nonzero only with valid |

## Verification
The hardest situation to reach is a second request arriving while a long mismatched-width request is still stepping, because only the per-element path is slow enough to leave a window, and the intruding request must change nothing. The bench raises `start` with an inverted source word in the first busy cycle of several stepping requests and compares the answer and the cycle of `valid` against a bit-by-bit model. Boundary counts are reached directly: VL at exactly 64/dw, one element past it, a source-side overflow with a narrow destination, and VL of zero in both endian modes.

// File: rtl/elw_repack_pkg.sv
package elw_repack_pkg;
    localparam int REG_W  = 64;
    localparam int VL_W   = $clog2(REG_W) + 1;
    localparam int AMT_W  = 16;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_FAST = 2'd1,
        S_STEP = 2'd2,
        S_DONE = 2'd3
    } rp_state_e;

    function automatic logic [7:0] bits_of(input logic [1:0] code);
        return 8'd8 << code;
    endfunction

    function automatic logic [REG_W-1:0] low_mask(input logic [AMT_W-1:0] n);
        if (n >= AMT_W'(REG_W)) return '1;
        return (REG_W'(1) << n) - REG_W'(1);
    endfunction
endpackage

// File: rtl/elw_elem_mover.sv
module elw_elem_mover
    import elw_repack_pkg::*;
#(
    parameter int IMM_W = 16
) (
    input  logic [REG_W-1:0] src,
    input  logic [IMM_W-1:0] imm,
    input  logic [1:0]       sw_code,
    input  logic [1:0]       dw_code,
    input  logic             be,
    input  logic [VL_W-1:0]  idx,
    output logic [REG_W-1:0] placed
);
    logic [AMT_W-1:0] s_bits, d_bits, s_off, d_off, pos;
    logic [REG_W-1:0] elem, imm_ext, val;

    always_comb begin
        s_bits = AMT_W'(bits_of(sw_code));
        d_bits = AMT_W'(bits_of(dw_code));
        pos    = AMT_W'(idx);
        s_off  = be ? AMT_W'(REG_W) - (pos + AMT_W'(1)) * s_bits : pos * s_bits;
        d_off  = be ? AMT_W'(REG_W) - (pos + AMT_W'(1)) * d_bits : pos * d_bits;
        elem    = (src >> s_off) & low_mask(s_bits);
        imm_ext = REG_W'(imm) & low_mask(d_bits);
        val     = (elem | imm_ext) & low_mask(d_bits);
        placed  = val << d_off;
    end
endmodule

// File: rtl/elw_fast_word.sv
module elw_fast_word
    import elw_repack_pkg::*;
#(
    parameter int IMM_W = 16
) (
    input  logic [REG_W-1:0] src,
    input  logic [IMM_W-1:0] imm,
    input  logic [1:0]       w_code,
    input  logic             be,
    input  logic [VL_W-1:0]  vl,
    output logic [REG_W-1:0] word
);
    localparam int IDX_W = $clog2(REG_W);

    logic [AMT_W-1:0] w_bits, n_bits;
    logic [IDX_W-1:0] lane_mask;
    logic [REG_W-1:0] imm_m, rep, region;

    always_comb begin
        w_bits    = AMT_W'(bits_of(w_code));
        lane_mask = IDX_W'(w_bits - AMT_W'(1));
        imm_m     = REG_W'(imm) & low_mask(w_bits);
        n_bits    = AMT_W'(vl) * w_bits;
        region    = be ? ~low_mask(AMT_W'(REG_W) - n_bits) : low_mask(n_bits);
    end

    for (genvar g = 0; g < REG_W; g++) begin : g_rep
        assign rep[g] = imm_m[IDX_W'(g) & lane_mask];
    end

    assign word = (src | rep) & region;
endmodule

// File: rtl/elw_repack.sv
module elw_repack
    import elw_repack_pkg::*;
#(
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [63:0]      src_word,
    input  logic [1:0]       sw_sel,
    input  logic [1:0]       dw_sel,
    input  logic [6:0]       vl,
    input  logic [IMM_W-1:0] imm,
    input  logic             be_mode,
    output logic             busy,
    output logic             valid,
    output logic             err,
    output logic [63:0]      result
);
    rp_state_e        state_q, state_d;
    logic [REG_W-1:0] src_q, acc_q, placed, fast;
    logic [IMM_W-1:0] imm_q;
    logic [1:0]       sw_q, dw_q;
    logic             be_q, err_q;
    logic [VL_W-1:0]  vl_q, idx_q;
    logic             accept, oversize, matched;

    assign accept   = start && (state_q == S_IDLE);
    assign oversize = (AMT_W'(vl) * AMT_W'(bits_of(sw_sel)) > AMT_W'(REG_W)) ||
                      (AMT_W'(vl) * AMT_W'(bits_of(dw_sel)) > AMT_W'(REG_W));
    assign matched  = (sw_sel == dw_sel) || (vl == '0);

    elw_elem_mover #(.IMM_W(IMM_W)) u_mover (
        .src(src_q), .imm(imm_q), .sw_code(sw_q), .dw_code(dw_q),
        .be(be_q), .idx(idx_q), .placed(placed)
    );

    elw_fast_word #(.IMM_W(IMM_W)) u_fast (
        .src(src_q), .imm(imm_q), .w_code(dw_q),
        .be(be_q), .vl(vl_q), .word(fast)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = oversize ? S_DONE : (matched ? S_FAST : S_STEP);
            S_FAST: state_d = S_DONE;
            S_STEP: if (idx_q == vl_q - VL_W'(1)) state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0; imm_q <= '0; sw_q <= '0; dw_q <= '0; be_q <= 1'b0;
            vl_q  <= '0; idx_q <= '0; acc_q <= '0; err_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (accept) begin
                    src_q <= src_word; imm_q <= imm; sw_q <= sw_sel; dw_q <= dw_sel;
                    be_q  <= be_mode;  vl_q  <= vl;  idx_q <= '0;
                    acc_q <= '0;       err_q <= oversize;
                end
                S_FAST: acc_q <= fast;
                S_STEP: begin
                    acc_q <= acc_q | placed;
                    idx_q <= idx_q + VL_W'(1);
                end
                S_DONE: ;
            endcase
        end
    end

    always_comb begin
        busy   = (state_q != S_IDLE);
        valid  = (state_q == S_DONE);
        err    = valid && err_q;
        result = valid ? acc_q : '0;
    end
endmodule

// File: rtl/elw_repack_checker.sv
module elw_repack_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [1:0]  sw_sel,
    input logic [1:0]  dw_sel,
    input logic [6:0]  vl,
    input logic        be_mode,
    input logic        busy,
    input logic        valid,
    input logic        err,
    input logic [63:0] result
);
    logic [6:0]  cap_vl;
    logic [1:0]  cap_dw;
    logic        cap_be, cap_bad;
    logic        in_bad, in_quick;
    logic [15:0] n_bits;
    logic [63:0] region;

    assign in_bad   = (16'(vl) * (16'd8 << sw_sel) > 16'd64) ||
                      (16'(vl) * (16'd8 << dw_sel) > 16'd64);
    assign in_quick = (sw_sel == dw_sel) || (vl == 7'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_vl <= '0; cap_dw <= '0; cap_be <= 1'b0; cap_bad <= 1'b0;
        end else if (start && !busy) begin
            cap_vl <= vl; cap_dw <= dw_sel; cap_be <= be_mode; cap_bad <= in_bad;
        end
    end

    always_comb begin
        n_bits = 16'(cap_vl) * (16'd8 << cap_dw);
        region = '0;
        for (int b = 0; b < 64; b++) begin
            if (cap_be) region[b] = (64 - b) <= int'(n_bits);
            else        region[b] = b < int'(n_bits);
        end
    end

    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    a_r8_busy_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> busy);
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !valid) |=> busy);
    a_r6_err_result_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && err) |-> (result == 64'd0));
    a_r6_err_matches: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (err == cap_bad));
    a_r5_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !err) |-> ((result & ~region) == 64'd0));
    a_r7_quick_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !in_bad && in_quick) |=> ##1 valid);
    a_r7_error_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && in_bad) |=> valid);
endmodule

bind elw_repack elw_repack_checker u_elw_repack_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .sw_sel(sw_sel), .dw_sel(dw_sel),
    .vl(vl), .be_mode(be_mode), .busy(busy), .valid(valid), .err(err),
    .result(result)
);

// File: tb/elw_repack_bench.sv
module elw_repack_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] src_word = '0;
    logic [1:0]  sw_sel = '0, dw_sel = '0;
    logic [6:0]  vl = '0;
    logic [15:0] imm = '0;
    logic        be_mode = 1'b0;
    logic        busy, valid, err;
    logic [63:0] result;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    elw_repack u_elw_repack (
        .clk(clk), .rst_n(rst_n), .start(start), .src_word(src_word),
        .sw_sel(sw_sel), .dw_sel(dw_sel), .vl(vl), .imm(imm), .be_mode(be_mode),
        .busy(busy), .valid(valid), .err(err), .result(result)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural model: bit by bit over elements; returns answer and edge count.
    task automatic model(input int swc, input int dwc, input int n, input logic [63:0] s,
                         input logic [15:0] im, input bit be,
                         output logic [63:0] res, output bit e, output int lat);
        int sb = 8 << swc;
        int db = 8 << dwc;
        res = '0;
        e = (n * sb > 64) || (n * db > 64);
        if (e) begin
            lat = 1;
            return;
        end
        lat = (swc == dwc || n == 0) ? 2 : n + 1;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < db; b++) begin
                logic sbit, ibit;
                int sp = be ? 64 - (i + 1) * sb + b : i * sb + b;
                int dp = be ? 64 - (i + 1) * db + b : i * db + b;
                sbit = (b < sb) ? s[sp] : 1'b0;
                ibit = (b < 16) ? im[b] : 1'b0;
                res[dp] = sbit | ibit;
            end
        end
    endtask

    // One request, compared on every clock until one cycle after the answer.
    task automatic run_op(input int swc, input int dwc, input int n, input logic [63:0] s,
                          input logic [15:0] im, input bit be, input bit poke, input string tag);
        logic [63:0] eres;
        bit eerr;
        int lat;
        model(swc, dwc, n, s, im, be, eres, eerr, lat);
        @(negedge clk);
        start = 1'b1; src_word = s; sw_sel = 2'(swc); dw_sel = 2'(dwc);
        vl = 7'(n); imm = im; be_mode = be;
        @(negedge clk);
        if (poke) begin
            src_word = ~s; vl = 7'd1; sw_sel = 2'd3; dw_sel = 2'd3; // R8 ignored while busy
        end else begin
            start = 1'b0;
        end
        for (int c = 1; c <= lat + 1; c++) begin
            chk(valid == (c == lat), {tag, " R7 valid timing"}, 64'(valid), 64'(c == lat));
            chk(busy == (c <= lat), {tag, " R8 busy"}, 64'(busy), 64'(c <= lat));
            if (c == lat) begin
                chk(result == eres, {tag, " result"}, result, eres);
                chk(err == eerr, {tag, " R6 err"}, 64'(err), 64'(eerr));
            end
            if (c == 1) start = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(!valid && !busy && !err && result == 0, "R8 reset outputs", {61'd0, valid, busy, err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!valid && !busy, "R8 idle after reset", {62'd0, valid, busy}, 64'd0);

        // R1 little-endian widening example
        run_op(0, 1, 4, 64'h0123_4567_89ab_cdef, 16'h0, 1'b0, 1'b0, "R1 le 8->16");
        // R2 big-endian widening example
        run_op(0, 1, 4, 64'h0123_4567_89ab_cdef, 16'h0, 1'b1, 1'b0, "R2 be 8->16");
        // R3 immediate masked to dw, zero extension
        run_op(0, 2, 2, 64'hfedc_ba98_7654_3210, 16'hf00f, 1'b0, 1'b0, "R3 le 8->32 imm");
        run_op(1, 3, 1, 64'h8001_0000_0000_0000, 16'h1234, 1'b1, 1'b0, "R3 be 16->64 imm");
        // R4 narrowing with truncation and masked immediate
        run_op(1, 0, 4, 64'h1122_3344_5566_7788, 16'hf0f0, 1'b0, 1'b0, "R4 le 16->8");
        run_op(2, 1, 2, 64'hdead_beef_cafe_f00d, 16'h0101, 1'b1, 1'b0, "R4 be 32->16");
        // R5 matched widths, partial region in both modes
        run_op(2, 2, 1, 64'hffff_ffff_ffff_ffff, 16'h00aa, 1'b0, 1'b0, "R5 le 32 vl1");
        run_op(2, 2, 1, 64'hffff_ffff_0000_0001, 16'h00aa, 1'b1, 1'b0, "R5 be 32 vl1");
        run_op(0, 0, 3, 64'h0102_0304_0506_0708, 16'h8080, 1'b1, 1'b0, "R5 be 8 vl3");
        run_op(3, 3, 1, 64'h0123_4567_89ab_cdef, 16'h00ff, 1'b0, 1'b0, "R5 le 64 vl1");
        // R6 oversize on destination and on source side, and exact fit
        run_op(0, 1, 5, 64'h0123_4567_89ab_cdef, 16'hffff, 1'b0, 1'b0, "R6 dst over");
        run_op(3, 0, 2, 64'h0123_4567_89ab_cdef, 16'h0, 1'b1, 1'b0, "R6 src over");
        run_op(0, 0, 9, 64'h0123_4567_89ab_cdef, 16'h0, 1'b0, 1'b0, "R6 same over");
        run_op(0, 0, 8, 64'h0123_4567_89ab_cdef, 16'h0011, 1'b0, 1'b0, "R6 exact fit");
        // R7 longest mismatched run
        run_op(0, 1, 4, 64'haaaa_5555_aaaa_5555, 16'h0303, 1'b1, 1'b0, "R7 step vl4");
        run_op(1, 0, 4, 64'h0f0f_f0f0_0f0f_f0f0, 16'h0000, 1'b1, 1'b0, "R7 step narrow be");
        // R8 start while busy ignored
        run_op(0, 1, 4, 64'h0123_4567_89ab_cdef, 16'h0, 1'b0, 1'b1, "R8 poke le");
        run_op(1, 0, 3, 64'h1122_3344_5566_7788, 16'h0440, 1'b1, 1'b1, "R8 poke be");
        // R9 zero-length vector
        run_op(0, 3, 0, 64'hffff_ffff_ffff_ffff, 16'hffff, 1'b0, 1'b0, "R9 vl0 le");
        run_op(2, 1, 0, 64'hffff_ffff_ffff_ffff, 16'hffff, 1'b1, 1'b0, "R9 vl0 be");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule